// File: doc/BRIEF.md
# ADC Conversion Queue Scan Controller

This block runs one queue of conversion command words through an analog-to-digital conversion engine. Software programs a small control register holding a 5-bit scan mode, a self-clearing scan-arm bit and two interrupt enables. The mode picks the trigger source for a single pass over the queue. The source is a software write, a rising or falling edge on an external trigger pin, or an internal interval timer that advances on a QCLK enable pulse. The timer period is a power of two between 2^7 and 2^15 QCLK periods.

Once a trigger is accepted, the controller asks the engine to convert CCW 0, then CCW 1 and so on. Requests go out on a valid/ready stream that carries the CCW index. The engine answers each conversion with a one-cycle done pulse that carries the CCW's pause and end-of-queue bits. A pause bit parks the queue until the next accepted trigger, and the scan then continues at the following CCW. The end-of-queue bit finishes the scan and disarms the block. Completion and pause interrupt flags are sticky, and software clears them by writing a one.

Back-pressure rule: while `conv_req_valid` is high and `conv_req_ready` is low, the request and its index are held unchanged. The only exception is a configuration write that disables the queue. Only one request is ever outstanding. The next request is raised only after the done pulse for the previous one.

Top module: `adc_queue_scan`

## Requirements
- R1: Mode code 0 disables the queue: no request is raised and no scan starts, whatever the arm bit or triggers do.
- R2: Mode codes 13 to 31 are reserved and behave exactly like code 0.
- R3: In mode 1, a configuration write with the arm bit set starts a scan at CCW index 0. The first request is visible two clock cycles after the write cycle.
- R4: In mode 2 a rising edge of `ext_trig` starts a scan, and in mode 3 a falling edge does. The opposite edge is ignored. The pin passes through two synchroniser flops, so the request appears in the third cycle after the pin changes.
- R5: Modes 4 to 12 trigger from an interval timer with a period of 2^(code+3) `qclk_en` pulses. Every configuration write restarts the timer. With `qclk_en` held high, the first request appears 2^(code+3)+1 cycles after the write cycle.
- R6: While the arm bit is clear, every trigger event is ignored. Triggers that arrive while a scan is running are also ignored.
- R7: The arm bit always reads back as 0 on `rd_sse`. The block clears the arm bit when a scan completes, so no further trigger starts a scan until the bit is written again.
- R8: Requests use a valid/ready stream. Valid and the index are held until ready is seen. Indices rise by one from 0, and each new request waits for the done pulse of the one before.
- R9: A done pulse with `conv_eoq`=1 ends the scan (`scan_busy` falls). If the completion enable is set, it also sets `irq_cmp`.
- R10: A done pulse with `conv_pause`=1 and `conv_eoq`=0 parks the queue (`scan_paused`=1). A pause bit sets `irq_pause` when the pause enable is set.
- R11: A parked queue resumes on the next accepted trigger, at the CCW after the one that paused.
- R12: Each interrupt flag stays set until its clear input is pulsed. The flag reads 0 in the cycle after the clear.
- R13: A configuration write of a disabled or reserved mode drops an active or parked scan to idle at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_mode | input | 5 | Scan mode code to write |
| cfg_sse | input | 1 | Arm bit to write |
| cfg_cie | input | 1 | Completion interrupt enable to write |
| cfg_pie | input | 1 | Pause interrupt enable to write |
| rd_mode | output | 5 | Current mode code |
| rd_sse | output | 1 | Arm bit readback, always 0 |
| rd_cie | output | 1 | Current completion interrupt enable |
| rd_pie | output | 1 | Current pause interrupt enable |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| qclk_en | input | 1 | One-cycle QCLK enable pulse for the interval timer |
| conv_req_valid | output | 1 | Conversion request valid |
| conv_req_ready | input | 1 | Engine accepts the request |
| conv_req_idx | output | IDX_W | CCW index of the request |
| conv_done | input | 1 | Conversion of the accepted CCW finished |
| conv_pause | input | 1 | Pause bit of the finished CCW |
| conv_eoq | input | 1 | End-of-queue bit of the finished CCW |
| irq_clr_cmp | input | 1 | Write-one clear of the completion flag |
| irq_clr_pause | input | 1 | Write-one clear of the pause flag |
| irq_cmp | output | 1 | Completion interrupt request |
| irq_pause | output | 1 | Pause interrupt request |
| scan_busy | output | 1 | A scan is active or parked |
| scan_paused | output | 1 | The queue is parked at a pause |

## Verification
The hardest state to reach from the ports is a queue that resumes after a pause with the index continuing rather than restarting. That case also needs the interrupt flags correct in each segment. To reach it, the bench's engine model serves requests with random ready and done delays. It draws pause masks and queue lengths at random, then re-arms in software mode after every pause. Each stop is compared with the first pause or end bit predicted by a bench function. The interval timer's exact latency, the restart of the timer by a fresh write, and an abort mid-scan are driven as directed cases.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
  localparam int MODE_W = 5;
  localparam logic [MODE_W-1:0] M_OFF    = 5'd0;
  localparam logic [MODE_W-1:0] M_SW     = 5'd1;
  localparam logic [MODE_W-1:0] M_RISE   = 5'd2;
  localparam logic [MODE_W-1:0] M_FALL   = 5'd3;
  localparam logic [MODE_W-1:0] M_TMR_LO = 5'd4;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_REQ   = 2'd1,
    S_WAIT  = 2'd2,
    S_PARK  = 2'd3
  } scan_st_t;
endpackage

// File: rtl/adcq_trig_sync.sv
module adcq_trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], pin};
  end

  // sh[1] is the synchronised level, sh[2] its previous value
  assign rise = sh[1] & ~sh[2];
  assign fall = ~sh[1] & sh[2];
endmodule

// File: rtl/adcq_interval_tmr.sv
module adcq_interval_tmr
  import adcq_pkg::*;
#(
  parameter int BASE_LOG2 = 7,
  parameter int STEPS     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              qclk_en,
  input  logic [MODE_W-1:0] mode,
  output logic              tick
);
  localparam int CNT_W = BASE_LOG2 + STEPS - 1;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last;
  logic [MODE_W-1:0] step;
  logic              sel_ok;

  always_comb begin
    step   = mode - M_TMR_LO;
    sel_ok = (mode >= M_TMR_LO) && (int'(step) < STEPS);
    last   = '1;
    for (int k = 0; k < STEPS; k++) begin
      if (int'(step) == k) last = CNT_W'((64'd1 << (BASE_LOG2 + k)) - 64'd1);
    end
  end

  assign tick = sel_ok && qclk_en && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (qclk_en) cnt <= tick ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/adcq_scan_fsm.sv
module adcq_scan_fsm
  import adcq_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             trig,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [IDX_W-1:0] req_idx,
  input  logic             done,
  input  logic             done_pause,
  input  logic             done_eoq,
  output logic             busy,
  output logic             parked,
  output logic             cmp_evt,
  output logic             pse_evt
);
  scan_st_t         st;
  logic [IDX_W-1:0] idx;
  logic             done_ok;

  assign done_ok   = (st == S_WAIT) && done;
  assign cmp_evt   = done_ok && done_eoq;
  assign pse_evt   = done_ok && done_pause;
  assign req_valid = (st == S_REQ);
  assign req_idx   = idx;
  assign busy      = (st != S_IDLE);
  assign parked    = (st == S_PARK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      idx <= '0;
    end else if (abort) begin
      st  <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: if (trig) begin
          st  <= S_REQ;
          idx <= '0;
        end
        S_REQ:  if (req_ready) st <= S_WAIT;
        S_WAIT: if (done) begin
          if (done_eoq) begin
            st <= S_IDLE;
          end else begin
            st  <= done_pause ? S_PARK : S_REQ;
            idx <= idx + 1'b1;
          end
        end
        S_PARK: if (trig) st <= S_REQ;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_queue_scan.sv
module adc_queue_scan
  import adcq_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int TMR_BASE  = 7,
  parameter int TMR_STEPS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [4:0]       cfg_mode,
  input  logic             cfg_sse,
  input  logic             cfg_cie,
  input  logic             cfg_pie,
  output logic [4:0]       rd_mode,
  output logic             rd_sse,
  output logic             rd_cie,
  output logic             rd_pie,
  input  logic             ext_trig,
  input  logic             qclk_en,
  output logic             conv_req_valid,
  input  logic             conv_req_ready,
  output logic [IDX_W-1:0] conv_req_idx,
  input  logic             conv_done,
  input  logic             conv_pause,
  input  logic             conv_eoq,
  input  logic             irq_clr_cmp,
  input  logic             irq_clr_pause,
  output logic             irq_cmp,
  output logic             irq_pause,
  output logic             scan_busy,
  output logic             scan_paused
);
  localparam logic [MODE_W-1:0] LAST_TMR = MODE_W'(int'(M_TMR_LO) + TMR_STEPS - 1);

  logic [MODE_W-1:0] mode_q;
  logic sse_q, cie_q, pie_q, sw_go_q;
  logic cmp_q, pse_q;
  logic ext_rise, ext_fall, tmr_tick;
  logic trig_raw, trig, abort;
  logic cmp_evt, pse_evt;

  function automatic logic mode_off(input logic [MODE_W-1:0] m);
    return (m == M_OFF) || (m > LAST_TMR);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_OFF;
      sse_q   <= 1'b0;
      cie_q   <= 1'b0;
      pie_q   <= 1'b0;
      sw_go_q <= 1'b0;
    end else begin
      sw_go_q <= cfg_wr && cfg_sse;
      if (cfg_wr) begin
        mode_q <= cfg_mode;
        sse_q  <= cfg_sse;
        cie_q  <= cfg_cie;
        pie_q  <= cfg_pie;
      end else if (cmp_evt) begin
        sse_q  <= 1'b0;
      end
    end
  end

  adcq_trig_sync u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (ext_trig),
    .rise (ext_rise),
    .fall (ext_fall)
  );

  adcq_interval_tmr #(
    .BASE_LOG2(TMR_BASE),
    .STEPS    (TMR_STEPS)
  ) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(cfg_wr),
    .qclk_en(qclk_en),
    .mode   (mode_q),
    .tick   (tmr_tick)
  );

  always_comb begin
    case (mode_q)
      M_SW:    trig_raw = sw_go_q;
      M_RISE:  trig_raw = ext_rise;
      M_FALL:  trig_raw = ext_fall;
      default: trig_raw = tmr_tick;
    endcase
  end

  assign trig  = trig_raw && sse_q && !mode_off(mode_q);
  assign abort = (cfg_wr && mode_off(cfg_mode)) || mode_off(mode_q);

  adcq_scan_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (abort),
    .trig      (trig),
    .req_valid (conv_req_valid),
    .req_ready (conv_req_ready),
    .req_idx   (conv_req_idx),
    .done      (conv_done),
    .done_pause(conv_pause),
    .done_eoq  (conv_eoq),
    .busy      (scan_busy),
    .parked    (scan_paused),
    .cmp_evt   (cmp_evt),
    .pse_evt   (pse_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= 1'b0;
      pse_q <= 1'b0;
    end else begin
      if (cmp_evt && cie_q)  cmp_q <= 1'b1;
      else if (irq_clr_cmp)  cmp_q <= 1'b0;
      if (pse_evt && pie_q)  pse_q <= 1'b1;
      else if (irq_clr_pause) pse_q <= 1'b0;
    end
  end

  assign irq_cmp   = cmp_q;
  assign irq_pause = pse_q;
  assign rd_mode   = mode_q;
  assign rd_sse    = 1'b0;
  assign rd_cie    = cie_q;
  assign rd_pie    = pie_q;
endmodule

// File: rtl/adcq_chk.sv
module adcq_chk #(
  parameter int IDX_W     = 6,
  parameter int TMR_STEPS = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [4:0]       rd_mode,
  input logic             conv_req_valid,
  input logic             conv_req_ready,
  input logic [IDX_W-1:0] conv_req_idx,
  input logic             conv_done,
  input logic             conv_pause,
  input logic             conv_eoq,
  input logic             irq_clr_cmp,
  input logic             irq_cmp,
  input logic             scan_busy,
  input logic             scan_paused
);
  localparam logic [4:0] LAST_CODE = 5'(4 + TMR_STEPS - 1);

  // R8
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_valid && !conv_req_ready && !cfg_wr) |=> (conv_req_valid && $stable(conv_req_idx)));

  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 5'd0) |-> (!conv_req_valid && !scan_busy));

  // R2
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode > LAST_CODE) |-> (!conv_req_valid && !scan_busy));

  // R12
  cmp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_cmp && !irq_clr_cmp) |=> irq_cmp);

  // R9
  cmp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_cmp) |-> $past(conv_done && conv_eoq));

  // R10
  park_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_paused) |-> $past(conv_done && conv_pause));
endmodule

bind adc_queue_scan adcq_chk #(.IDX_W(IDX_W), .TMR_STEPS(TMR_STEPS)) u_chk (.*);

// File: tb/sim_adc_queue_scan.sv
module sim_adc_queue_scan;
  localparam int IDX_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_sse = 0, cfg_cie = 0, cfg_pie = 0;
  logic [4:0] cfg_mode = 0;
  logic [4:0] rd_mode;
  logic rd_sse, rd_cie, rd_pie;
  logic ext_trig = 0, qclk_en = 1;
  logic conv_req_valid, conv_req_ready;
  logic [IDX_W-1:0] conv_req_idx;
  logic conv_done, conv_pause, conv_eoq;
  logic irq_clr_cmp = 0, irq_clr_pause = 0;
  logic irq_cmp, irq_pause, scan_busy, scan_paused;

  int checks = 0, fails = 0;
  int exp_idx = 0, served = 0, qlen = 4;
  logic [31:0] pmask = '0;

  always #10 clk = ~clk;

  adc_queue_scan #(.IDX_W(IDX_W)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // conversion engine model
  initial begin
    int cur;
    conv_req_ready = 0; conv_done = 0; conv_pause = 0; conv_eoq = 0;
    forever begin
      @(negedge clk);
      if (conv_req_valid) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        cur = int'(conv_req_idx);
        conv_req_ready = 1;
        @(negedge clk);
        conv_req_ready = 0;
        chk(cur == exp_idx, "R8 index order", cur, exp_idx);
        exp_idx = cur + 1;
        served++;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        conv_done = 1; conv_pause = pmask[cur]; conv_eoq = (cur == qlen - 1);
        @(negedge clk);
        conv_done = 0; conv_pause = 0; conv_eoq = 0;
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic wr(input logic [4:0] m, input logic s, input logic c, input logic p);
    cfg_mode = m; cfg_sse = s; cfg_cie = c; cfg_pie = p; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0; cfg_sse = 0;
  endtask

  task automatic clr_flags();
    irq_clr_cmp = 1; irq_clr_pause = 1;
    @(negedge clk);
    irq_clr_cmp = 0; irq_clr_pause = 0;
  endtask

  // wait for a running (unparked) scan, then for it to stop or park
  task automatic run_seg(output bit ok);
    int i;
    ok = 0;
    for (i = 0; i < 40000; i++) begin
      if (scan_busy && !scan_paused) break;
      @(negedge clk);
    end
    for (int j = 0; j < 2000; j++) begin
      if (!scan_busy || scan_paused) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic quiet(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (conv_req_valid || scan_busy) seen++;
    end
  endtask

  function automatic int next_stop(input int start, input int len, input logic [31:0] m);
    for (int i = start; i < len; i++) if (m[i] || i == len - 1) return i;
    return len - 1;
  endfunction

  task automatic lat_from_write(input logic [4:0] m, output int n);
    wr(m, 1, 0, 0);
    n = 1;
    while (!conv_req_valid && n < 40000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    bit ok;
    int n, seen;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    chk(!conv_req_valid && !scan_busy && !irq_cmp && !irq_pause, "reset outputs", int'(scan_busy), 0);
    chk(rd_mode == 0 && rd_sse == 0, "reset mode", int'(rd_mode), 0);

    // R1 and R2: disabled and reserved codes
    wr(5'd0, 1, 1, 1); quiet(30, seen);
    chk(seen == 0, "R1 mode 0 quiet", seen, 0);
    wr(5'd13, 1, 1, 1); quiet(300, seen);
    chk(seen == 0, "R2 code 13 quiet", seen, 0);
    wr(5'd31, 1, 1, 1); quiet(30, seen);
    chk(seen == 0, "R2 code 31 quiet", seen, 0);

    // R3 software single scan with latency, R9 completion, R7 readback
    qlen = 4; pmask = 0; exp_idx = 0; served = 0;
    wr(5'd1, 1, 1, 0);
    n = 1;
    while (!conv_req_valid && n < 50) begin @(negedge clk); n++; end
    chk(n == 2, "R3 sw start latency", n, 2);
    chk(conv_req_idx == 0, "R3 first index", int'(conv_req_idx), 0);
    chk(rd_sse == 0, "R7 arm reads zero", int'(rd_sse), 0);
    run_seg(ok);
    chk(ok && !scan_busy, "R9 scan ends", int'(scan_busy), 0);
    chk(served == 4, "R8 all CCWs", served, 4);
    chk(irq_cmp == 1, "R9 completion flag", int'(irq_cmp), 1);
    repeat (5) @(negedge clk);
    chk(irq_cmp == 1, "R12 flag sticky", int'(irq_cmp), 1);
    clr_flags();
    chk(irq_cmp == 0, "R12 flag cleared", int'(irq_cmp), 0);

    // R4 rising edge, latency through synchroniser
    exp_idx = 0; served = 0;
    wr(5'd2, 1, 0, 0);
    ext_trig = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (!scan_busy && n < 50);
    chk(n == 3, "R4 rise latency", n, 3);
    run_seg(ok);
    chk(served == 4 && !irq_cmp, "R9 no flag when disabled", int'(irq_cmp), 0);
    // R7 disarmed after completion
    ext_trig = 0; repeat (4) @(negedge clk);
    ext_trig = 1; quiet(10, seen);
    chk(seen == 0, "R7 disarmed after scan", seen, 0);
    // R6 written clear: rising edge ignored
    wr(5'd2, 0, 0, 0);
    ext_trig = 0; repeat (4) @(negedge clk);
    ext_trig = 1; quiet(10, seen);
    chk(seen == 0, "R6 arm clear ignores edge", seen, 0);

    // R4 falling-edge mode ignores rise
    ext_trig = 0; repeat (4) @(negedge clk);
    wr(5'd3, 1, 0, 0);
    ext_trig = 1; quiet(10, seen);
    chk(seen == 0, "R4 fall mode ignores rise", seen, 0);
    exp_idx = 0; served = 0;
    ext_trig = 0;
    n = 0;
    do begin @(negedge clk); n++; end while (!scan_busy && n < 50);
    chk(n == 3, "R4 fall latency", n, 3);
    run_seg(ok);
    chk(served == 4, "R4 fall scan done", served, 4);

    // R5 interval timer latency, codes 4 and 5, and restart on write
    exp_idx = 0; served = 0;
    lat_from_write(5'd4, n);
    chk(n == 129, "R5 code 4 period", n, 129);
    run_seg(ok);
    exp_idx = 0; served = 0;
    lat_from_write(5'd5, n);
    chk(n == 257, "R5 code 5 period", n, 257);
    run_seg(ok);
    exp_idx = 0; served = 0;
    wr(5'd4, 1, 0, 0);
    repeat (99) @(negedge clk);
    lat_from_write(5'd4, n);
    chk(n == 129, "R5 timer restart on write", n, 129);
    run_seg(ok);

    // R10 R11 pause then resume
    qlen = 5; pmask = 32'b10; exp_idx = 0; served = 0;
    clr_flags();
    wr(5'd1, 1, 1, 1);
    run_seg(ok);
    chk(scan_paused == 1, "R10 parked", int'(scan_paused), 1);
    chk(irq_pause == 1 && irq_cmp == 0, "R10 pause flag", int'(irq_pause), 1);
    chk(served == 2, "R10 stop point", served, 2);
    irq_clr_pause = 1; @(negedge clk); irq_clr_pause = 0;
    chk(irq_pause == 0, "R12 pause flag cleared", int'(irq_pause), 0);
    wr(5'd1, 1, 1, 1);
    run_seg(ok);
    chk(!scan_busy && exp_idx == 5, "R11 resume at next CCW", exp_idx, 5);
    chk(irq_cmp == 1, "R11 completion after resume", int'(irq_cmp), 1);

    // R13 abort mid-scan
    qlen = 30; pmask = 0; exp_idx = 0; served = 0;
    clr_flags();
    wr(5'd1, 1, 0, 0);
    repeat (6) @(negedge clk);
    wr(5'd0, 0, 0, 0);
    chk(!scan_busy && !conv_req_valid, "R13 abort to idle", int'(scan_busy), 0);
    repeat (10) @(negedge clk);

    // random segments in software mode
    for (int it = 0; it < 14; it++) begin
      int start, stop;
      logic c, p;
      qlen = $urandom_range(1, 8);
      pmask = 32'($urandom_range(0, 255)) & 32'($urandom_range(0, 255));
      c = 1'($urandom_range(0, 1)); p = 1'($urandom_range(0, 1));
      exp_idx = 0; served = 0; start = 0;
      clr_flags();
      while (start < qlen) begin
        wr(5'd1, 1, c, p);
        chk(rd_cie == c && rd_pie == p, "R3 readback", int'(rd_cie), int'(c));
        run_seg(ok);
        stop = next_stop(start, qlen, pmask);
        chk(served == stop + 1, "R11 random stop", served, stop + 1);
        chk(irq_pause == (p && pmask[stop]), "R10 random pause flag", int'(irq_pause), int'(p && pmask[stop]));
        if (stop == qlen - 1) begin
          chk(!scan_busy && irq_cmp == c, "R9 random completion", int'(irq_cmp), int'(c));
        end else begin
          chk(scan_paused == 1, "R10 random parked", int'(scan_paused), 1);
        end
        clr_flags();
        start = stop + 1;
      end
    end

    summary();
    $finish;
  end
endmodule